// File: doc/BRIEF.md
# Register-Controlled Pulse-Width Modulator Channel

This block produces one pulse-width modulated output from a clock-synchronous register bank of four 32-bit words. Software programs a period length and an active length, both counted in clock cycles. It then sets control fields to start the channel. While the channel runs, a counter repeats from zero to period minus one. The output holds its active level for the first `duty` counts of every period and its inactive level for the rest.

The active level and the resting level are two independent control bits. When stopped, the output sits at the resting level. Changes to period and duty written while the channel runs are held in a pending copy. The counter adopts them only when it wraps, so a period already in progress always completes with the values it started with. The counter word reads back the live count.

Top module: `pwm_channel`

## Requirements
- R1: Registers are selected by byte address bits [3:2]: 0x0 counter, 0x4 period, 0x8 duty, 0xC control. Period, duty and control read back exactly the 32-bit value last written. Read data is combinational from the address. All registers reset to zero.
- R2: Reading offset 0x0 returns the live counter value. Writes to offset 0x0 change nothing.
- R3: The channel runs only when control bit 0 = 1, bit 1 = 1, bit 5 = 0 and bit 8 = 0. In any other case the counter is held at zero and the output shows the resting level.
- R4: While the channel is not running, the output equals control bit 4 (1 = rest high, 0 = rest low).
- R5: While running with a nonzero period, the output equals control bit 3 when counter < duty, and the inverse of bit 3 otherwise.
- R6: From the clock edge that starts the channel, the counter reads 0. It then advances by one each clock and returns to 0 after period minus 1. After j edges the count is j mod period.
- R7: A duty greater than or equal to the period gives an output held at the active level (bit 3) for the whole period.
- R8: A period of zero while running holds the counter at zero and the output at the resting level (bit 4).
- R9: A period or duty write that lands while running takes effect at the first counter wrap strictly after the write edge. While the channel is stopped, new values take effect at once.
- R10: Control bits other than 0, 1, 3, 4, 5 and 8 read back as written and do not affect the output or the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| pwm_out | output | 1 | Modulated output |

## Verification
A period or duty write can arrive on the same edge as a counter wrap. The wrap copies the pending values into the active compare registers in that cycle. The bench makes this happen by timing a duty write so it lands exactly on a wrap edge. The bench then requires the old duty for the whole next period and the new duty only from the wrap after that. A counter write is also issued on a running edge, and the count must continue unchanged.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int unsigned PWM_DW = 32;
    localparam int unsigned PWM_AW = 4;
    localparam int unsigned SEL_LSB = 2;

    localparam logic [1:0] SEL_CNT  = 2'd0;
    localparam logic [1:0] SEL_PER  = 2'd1;
    localparam logic [1:0] SEL_DUTY = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam int unsigned B_RUN   = 0;
    localparam int unsigned B_REP   = 1;
    localparam int unsigned B_ACT   = 3;
    localparam int unsigned B_REST  = 4;
    localparam int unsigned B_ALIGN = 5;
    localparam int unsigned B_LOWP  = 8;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int unsigned DATA_W = PWM_DW,
    parameter int unsigned ADDR_W = PWM_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] live_cnt,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] per_pend,
    output logic [DATA_W-1:0] duty_pend,
    output logic              run,
    output logic              act_lvl,
    output logic              rest_lvl
);
    localparam int unsigned SEL_W = 2;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] per;
        logic [DATA_W-1:0] duty;
    } regs_t;

    regs_t             r_d, r_q;
    logic [SEL_W-1:0]  sel;
    logic              unused_addr_bits;

    assign sel              = addr[SEL_LSB +: SEL_W];
    assign unused_addr_bits = ^{addr[SEL_LSB-1:0], addr[ADDR_W-1:SEL_LSB+SEL_W]};

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (sel)
                SEL_PER:  r_d.per  = wdata;
                SEL_DUTY: r_d.duty = wdata;
                SEL_CTRL: r_d.ctrl = wdata;
                default:  r_d      = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (sel)
            SEL_CNT:  rdata = live_cnt;
            SEL_PER:  rdata = r_q.per;
            SEL_DUTY: rdata = r_q.duty;
            default:  rdata = r_q.ctrl;
        endcase
    end

    assign per_pend  = r_q.per;
    assign duty_pend = r_q.duty;
    assign run       = r_q.ctrl[B_RUN] & r_q.ctrl[B_REP] &
                       ~r_q.ctrl[B_ALIGN] & ~r_q.ctrl[B_LOWP];
    assign act_lvl   = r_q.ctrl[B_ACT];
    assign rest_lvl  = r_q.ctrl[B_REST];
endmodule

// File: rtl/pwm_engine.sv
module pwm_engine #(
    parameter int unsigned DATA_W = pwm_pkg::PWM_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DATA_W-1:0] per_pend,
    input  logic [DATA_W-1:0] duty_pend,
    output logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] per_act,
    output logic [DATA_W-1:0] duty_act,
    output logic              wrap,
    output logic              per_zero,
    output logic              in_duty
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] per;
        logic [DATA_W-1:0] duty;
    } eng_t;

    eng_t e_d, e_q;

    assign per_zero = (e_q.per == '0);
    assign wrap     = per_zero || (e_q.cnt >= e_q.per - ONE);
    assign in_duty  = (e_q.cnt < e_q.duty);

    always_comb begin
        e_d = e_q;
        if (!run || wrap) begin
            e_d.cnt  = '0;
            e_d.per  = per_pend;
            e_d.duty = duty_pend;
        end else begin
            e_d.cnt  = e_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign cnt      = e_q.cnt;
    assign per_act  = e_q.per;
    assign duty_act = e_q.duty;
endmodule

// File: rtl/pwm_outsel.sv
module pwm_outsel (
    input  logic run,
    input  logic per_zero,
    input  logic in_duty,
    input  logic act_lvl,
    input  logic rest_lvl,
    output logic pwm_o
);
    always_comb begin
        if (!run || per_zero) pwm_o = rest_lvl;
        else if (in_duty)     pwm_o = act_lvl;
        else                  pwm_o = ~act_lvl;
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int unsigned DATA_W = PWM_DW,
    parameter int unsigned ADDR_W = PWM_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);
    logic [DATA_W-1:0] cnt, per_act, duty_act, per_pend, duty_pend;
    logic              run, act_lvl, rest_lvl, wrap, per_zero, in_duty;

    pwm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .live_cnt  (cnt),
        .rdata     (bus_rdata),
        .per_pend  (per_pend),
        .duty_pend (duty_pend),
        .run       (run),
        .act_lvl   (act_lvl),
        .rest_lvl  (rest_lvl)
    );

    pwm_engine #(.DATA_W(DATA_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .per_pend  (per_pend),
        .duty_pend (duty_pend),
        .cnt       (cnt),
        .per_act   (per_act),
        .duty_act  (duty_act),
        .wrap      (wrap),
        .per_zero  (per_zero),
        .in_duty   (in_duty)
    );

    pwm_outsel u_out (
        .run      (run),
        .per_zero (per_zero),
        .in_duty  (in_duty),
        .act_lvl  (act_lvl),
        .rest_lvl (rest_lvl),
        .pwm_o    (pwm_out)
    );
endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk #(
    parameter int unsigned DATA_W = pwm_pkg::PWM_DW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              wrap,
    input logic              act_lvl,
    input logic              rest_lvl,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] per_act,
    input logic [DATA_W-1:0] duty_act,
    input logic              pwm_out
);
    p_held_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);

    p_rest_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> pwm_out == rest_lvl);

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> cnt == $past(cnt) + DATA_W'(1));

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && per_act != '0) |-> cnt < per_act);

    p_full_duty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && per_act != '0 && duty_act >= per_act) |-> pwm_out == act_lvl);

    p_zero_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && per_act == '0) |-> pwm_out == rest_lvl);

    p_hold_midperiod_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> ($stable(per_act) && $stable(duty_act)));
endmodule

bind pwm_channel pwm_channel_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .wrap     (wrap),
    .act_lvl  (act_lvl),
    .rest_lvl (rest_lvl),
    .cnt      (cnt),
    .per_act  (per_act),
    .duty_act (duty_act),
    .pwm_out  (pwm_out)
);

// File: tb/sim_pwm_channel.sv
`timescale 1ns/1ps
module sim_pwm_channel;
    localparam logic [3:0] A_CNT = 4'h0, A_PER = 4'h4, A_DUTY = 4'h8, A_CTRL = 4'hC;
    localparam int NVEC = 8;
    localparam int NCYC = 20;
    // {period, duty, control}
    localparam logic [95:0] VECS [NVEC] = '{
        {32'd5, 32'd2, 32'h0000_000B},
        {32'd5, 32'd2, 32'h0000_0013},
        {32'd4, 32'd4, 32'h0000_000B},
        {32'd4, 32'd9, 32'h0000_000B},
        {32'd6, 32'd0, 32'h0000_000B},
        {32'd1, 32'd1, 32'h0000_000B},
        {32'd0, 32'd3, 32'h0000_0013},
        {32'd7, 32'd3, 32'hA5A5_A0CF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pwm_channel u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    function automatic logic exp_out(input logic [31:0] p, input logic [31:0] d,
                                     input logic [31:0] c, input int j);
        if (p == 0) return c[4];
        return ((32'(j) % p) < d) ? c[3] : ~c[3];
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset out", 32'(pwm_out), 32'd0);
        rd_chk("R1 reset cnt", A_CNT, 32'd0);
        rd_chk("R1 reset per", A_PER, 32'd0);
        rd_chk("R1 reset duty", A_DUTY, 32'd0);
        rd_chk("R1 reset ctrl", A_CTRL, 32'd0);

        // Table walk: R1 readback, R5 R6 R7 R8 R10 behaviour
        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] p, d, c;
            {p, d, c} = VECS[v];
            wr(A_CTRL, 32'd0);
            wr(A_PER, p);
            wr(A_DUTY, d);
            rd_chk("R1 per readback", A_PER, p);
            rd_chk("R1 duty readback", A_DUTY, d);
            wr(A_CTRL, c);
            rd_chk("R1 R10 ctrl readback", A_CTRL, c);
            for (int j = 0; j < NCYC; j++) begin
                if (j > 0) @(negedge clk);
                rd_chk("R6 R8 live count", A_CNT, (p == 0) ? 32'd0 : 32'(j) % p);
                chk("R5 R7 R8 R10 output", 32'(pwm_out), 32'(exp_out(p, d, c, j)));
            end
        end

        // R3 / R4: fields that stop the channel, resting level high
        begin
            logic [31:0] stops [4] = '{32'h19, 32'h3B, 32'h11B, 32'h1A};
            wr(A_CTRL, 32'd0);
            wr(A_PER, 32'd5);
            wr(A_DUTY, 32'd2);
            for (int k = 0; k < 4; k++) begin
                wr(A_CTRL, stops[k]);
                repeat (3) @(negedge clk);
                rd_chk("R3 stopped count", A_CNT, 32'd0);
                chk("R3 R4 stopped output", 32'(pwm_out), 32'd1);
            end
            wr(A_CTRL, 32'd0);
            chk("R4 rest low", 32'(pwm_out), 32'd0);
        end

        // R2: counter writes ignored, stopped and running
        wr(A_CNT, 32'h1234);
        rd_chk("R2 stopped cnt write", A_CNT, 32'd0);
        wr(A_PER, 32'd10);
        wr(A_DUTY, 32'd3);
        wr(A_CTRL, 32'h0B);
        bus_addr = A_CNT; bus_we = 1'b1; bus_wdata = 32'd7;
        @(negedge clk);
        bus_we = 1'b0;
        rd_chk("R2 running cnt write", A_CNT, 32'd1);
        chk("R2 output after cnt write", 32'(pwm_out), 32'd1);

        // R9: pending values, including a duty write landing on a wrap edge
        wr(A_CTRL, 32'd0);
        wr(A_PER, 32'd4);
        wr(A_DUTY, 32'd1);
        wr(A_CTRL, 32'h0B);
        chk("R9 start j0", 32'(pwm_out), 32'd1);
        @(negedge clk);
        chk("R9 j1", 32'(pwm_out), 32'd0);
        bus_addr = A_DUTY; bus_we = 1'b1; bus_wdata = 32'd3;
        @(negedge clk);
        chk("R9 j2 old duty", 32'(pwm_out), 32'd0);
        bus_addr = A_PER; bus_wdata = 32'd6;
        @(negedge clk);
        bus_we = 1'b0;
        bus_addr = A_CNT;
        rd_chk("R9 j3 old period count", A_CNT, 32'd3);
        chk("R9 j3 old duty", 32'(pwm_out), 32'd0);
        for (int j = 4; j < 18; j++) begin
            @(negedge clk);
            if (j == 10) bus_we = 1'b0;
            rd_chk("R9 count after wrap", A_CNT, 32'((j - 4) % 6));
            chk("R9 output after wrap", 32'(pwm_out),
                (((j - 4) % 6) < ((j >= 16) ? 3'd1 : 3'd3)) ? 32'd1 : 32'd0);
            if (j == 9) begin
                bus_addr = A_DUTY; bus_we = 1'b1; bus_wdata = 32'd1;
            end else if (j != 10) begin
                bus_addr = A_CNT;
            end
            if (j == 10) bus_addr = A_CNT;
        end

        wr(A_CTRL, 32'd0);
        finish_run();
    end
endmodule